// File: doc/BRIEF.md
# VMEbus Slave Window Decoder

This block decides whether an address phase seen on the VMEbus belongs to one of eight programmable slave windows, and which one. Each window has a base, a bound, an enable, and settings for address space, privilege and access type. The block accepts an address and the 6-bit address modifier (AM) when an address-strobe qualifier is high. One clock later it reports a hit flag, the index of the winning window and an overlap flag.

All windows live in the 32-bit address range. Windows 0 and 4 use 4 KB granularity. The other six use 64 KB granularity. An address matches a window only if it falls inside the window and the AM code is one that the window accepts. The accepted codes come from the window's space, privilege and type settings. Two further codes, the user codes, sit in their own register, and a window may opt to accept them.

A simple write port loads every setting. Because the result is registered and only changes on a qualified phase, a new address phase can be presented on every clock.

Top module: `vme_slave_decode`

## Requirements
- R1: After reset, hit, idx and overlap are 0. The two user AM codes are 0x10 and 0x1F.
- R2: A phase presented with as_valid high at one rising edge updates hit, idx and overlap at that edge. While as_valid is low the three outputs hold their values.
- R3: A window matches when base <= addr < bound, with all three values compared after clearing the low bits. Windows 0 and 4 clear bits [11:0]. All other windows clear bits [15:0].
- R4: A window whose masked bound is at or below its masked base never matches.
- R5: A window whose enable bit (control bit 0) is 0 never matches.
- R6: Control bits [2:1] select the space: 0 = A16, 1 = A24, 2 = A32, 3 = CR/CSR. Bit 3 allows supervisor access, bit 4 allows non-privileged access, bit 5 allows program access and bit 6 allows data access. For A32 the accepted codes are 0x0D (supervisor data), 0x0E (supervisor program), 0x09 (non-privileged data) and 0x0A (non-privileged program). For A24 the corresponding codes are 0x3D, 0x3E, 0x39 and 0x3A.
- R7: For A16, the type bits are ignored: 0x2D is accepted with bit 3 set and 0x29 with bit 4 set. For CR/CSR, 0x2F is accepted regardless of bits 3 to 6.
- R8: When control bit 7 is set, an AM equal to either user code is also accepted, whatever the space. The user register holds code 0 in bits [5:0] and code 1 in bits [13:8].
- R9: When several windows match, idx is the lowest matching index. On a miss, idx is 0.
- R10: overlap is 1 exactly when more than one window matches the phase. overlap implies hit.
- R11: Writes use cfg_sel[4:3] as the group (0 = control, 1 = base, 2 = bound, 3 = user codes) and cfg_sel[2:0] as the window. A write is used by any phase presented from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setting write enable |
| cfg_sel | input | 5 | Group and window select |
| cfg_wdata | input | 32 | Setting write data |
| vme_addr | input | 32 | Address of the phase |
| vme_am | input | 6 | Address modifier of the phase |
| as_valid | input | 1 | Address phase qualifier |
| hit | output | 1 | Some window matched the last phase |
| hit_idx | output | 3 | Winning window index |
| overlap_err | output | 1 | More than one window matched |

## Verification
Every decode result is due at the first rising edge on which as_valid is high. The bench therefore drives each phase just after a falling edge, holds it through one rising edge, and compares at the following falling edge. A setting write is made the same way, so the phase after it already sees the new value. After a phase, the bench changes the address and AM with the qualifier low and checks one edge later that none of the three outputs moved.

// File: rtl/vme_slave_decode.sv
module vme_slave_decode #(
  parameter int NUM_IMG = 8,
  parameter int AW = 32,
  parameter int FINE_RES = 12,
  parameter int COARSE_RES = 16,
  parameter logic [5:0] UAM0_RST = 6'h10,
  parameter logic [5:0] UAM1_RST = 6'h1F
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [$clog2(NUM_IMG)+1:0] cfg_sel,
  input  logic [31:0]                cfg_wdata,
  input  logic [AW-1:0]              vme_addr,
  input  logic [5:0]                 vme_am,
  input  logic                       as_valid,
  output logic                       hit,
  output logic [$clog2(NUM_IMG)-1:0] hit_idx,
  output logic                       overlap_err
);
  localparam int IW = $clog2(NUM_IMG);

  logic [7:0]    ctl   [NUM_IMG];
  logic [AW-1:0] base  [NUM_IMG];
  logic [AW-1:0] bound [NUM_IMG];
  logic [5:0]    uam0, uam1;
  logic [NUM_IMG-1:0] match, en_vec;

  wire [1:0]    grp = cfg_sel[IW+1:IW];
  wire [IW-1:0] img = cfg_sel[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IMG; i++) begin
        ctl[i]   <= '0;
        base[i]  <= '0;
        bound[i] <= '0;
      end
      uam0 <= UAM0_RST;
      uam1 <= UAM1_RST;
    end else if (cfg_we) begin
      case (grp)
        2'd0: ctl[img]   <= cfg_wdata[7:0];
        2'd1: base[img]  <= cfg_wdata[AW-1:0];
        2'd2: bound[img] <= cfg_wdata[AW-1:0];
        default: begin
          uam0 <= cfg_wdata[5:0];
          uam1 <= cfg_wdata[13:8];
        end
      endcase
    end
  end

  wire user_am = (vme_am == uam0) || (vme_am == uam1);
  wire am_prv  = vme_am[2] ? 1'b1 : 1'b0;

  for (genvar g = 0; g < NUM_IMG; g++) begin : g_img
    localparam int RES = (g % 4 == 0) ? FINE_RES : COARSE_RES;
    localparam logic [AW-1:0] MSK = {{(AW-RES){1'b1}}, {RES{1'b0}}};

    wire [AW-1:0] a_m = vme_addr & MSK;
    wire [AW-1:0] b_m = base[g] & MSK;
    wire [AW-1:0] t_m = bound[g] & MSK;
    wire in_win = (a_m >= b_m) && (a_m < t_m);

    wire sup = ctl[g][3];
    wire np  = ctl[g][4];
    wire prg = ctl[g][5];
    wire dat = ctl[g][6];
    wire priv_ok = am_prv ? sup : np;
    wire type_ok = (vme_am[1:0] == 2'b01 && dat) || (vme_am[1:0] == 2'b10 && prg);

    logic std_ok;
    always_comb begin
      case (ctl[g][2:1])
        2'd0:    std_ok = vme_am[5:3] == 3'b101 && vme_am[1:0] == 2'b01 && priv_ok;
        2'd1:    std_ok = vme_am[5:3] == 3'b111 && priv_ok && type_ok;
        2'd2:    std_ok = vme_am[5:3] == 3'b001 && priv_ok && type_ok;
        default: std_ok = vme_am == 6'h2F;
      endcase
    end

    assign en_vec[g] = ctl[g][0];
    assign match[g]  = en_vec[g] && in_win && (std_ok || (ctl[g][7] && user_am));
  end

  logic [IW-1:0] idx_n;
  always_comb begin
    idx_n = '0;
    for (int i = NUM_IMG - 1; i >= 0; i--)
      if (match[i]) idx_n = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit         <= 1'b0;
      hit_idx     <= '0;
      overlap_err <= 1'b0;
    end else if (as_valid) begin
      hit         <= |match;
      hit_idx     <= idx_n;
      overlap_err <= $countones(match) > 1;
    end
  end
endmodule

module vme_slave_decode_chk #(
  parameter int NUM_IMG = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       as_valid,
  input logic                       hit,
  input logic [$clog2(NUM_IMG)-1:0] hit_idx,
  input logic                       overlap_err,
  input logic [NUM_IMG-1:0]         en_vec
);
  logic [NUM_IMG-1:0] en_d;
  always_ff @(posedge clk) en_d <= en_vec;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !as_valid |=> $stable({hit, hit_idx, overlap_err}));

  // R10
  overlap_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_err |-> hit);

  // R9
  miss_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> hit_idx == '0);

  // R5
  winner_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    as_valid |=> (!hit || en_d[hit_idx]));
endmodule

bind vme_slave_decode vme_slave_decode_chk #(.NUM_IMG(NUM_IMG)) u_chk (
  .clk(clk), .rst_n(rst_n), .as_valid(as_valid), .hit(hit),
  .hit_idx(hit_idx), .overlap_err(overlap_err), .en_vec(en_vec)
);

// File: tb/tb_vme_slave_decode.sv
module tb_vme_slave_decode;
  logic clk = 0, rst_n = 0, cfg_we = 0, as_valid = 0;
  logic [4:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0, vme_addr = 0;
  logic [5:0] vme_am = 0;
  logic hit, overlap_err;
  logic [2:0] hit_idx;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vme_slave_decode dut (.*);

  logic [7:0]  m_ctl [8];
  logic [31:0] m_base [8], m_bound [8];
  logic [5:0]  m_u0 = 6'h10, m_u1 = 6'h1F;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit am_ok(logic [7:0] c, logic [5:0] am);
    bit ok = 0;
    if (c[7] && (am == m_u0 || am == m_u1)) ok = 1;
    case (c[2:1])
      2'd0: if ((am == 6'h2D && c[3]) || (am == 6'h29 && c[4])) ok = 1;
      2'd1: if ((am == 6'h3D && c[3] && c[6]) || (am == 6'h3E && c[3] && c[5]) ||
                (am == 6'h39 && c[4] && c[6]) || (am == 6'h3A && c[4] && c[5])) ok = 1;
      2'd2: if ((am == 6'h0D && c[3] && c[6]) || (am == 6'h0E && c[3] && c[5]) ||
                (am == 6'h09 && c[4] && c[6]) || (am == 6'h0A && c[4] && c[5])) ok = 1;
      default: if (am == 6'h2F) ok = 1;
    endcase
    return ok;
  endfunction

  function automatic bit img_hit(int i, logic [31:0] a, logic [5:0] am);
    int sh = (i == 0 || i == 4) ? 12 : 16;
    logic [31:0] aa = a >> sh, bb = m_base[i] >> sh, tt = m_bound[i] >> sh;
    return m_ctl[i][0] && bb <= aa && aa < tt && am_ok(m_ctl[i], am);
  endfunction

  task automatic wr(logic [1:0] grp, logic [2:0] i, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = {grp, i}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (grp)
      2'd0: m_ctl[i] = d[7:0];
      2'd1: m_base[i] = d;
      2'd2: m_bound[i] = d;
      default: begin m_u0 = d[5:0]; m_u1 = d[13:8]; end
    endcase
  endtask

  task automatic setimg(int i, logic [7:0] c, logic [31:0] b, logic [31:0] t);
    wr(2'd1, 3'(i), b); wr(2'd2, 3'(i), t); wr(2'd0, 3'(i), c);
  endtask

  task automatic phase(string req, logic [31:0] a, logic [5:0] am);
    int n = 0, first = 0;
    logic eh, eo; logic [2:0] ei;
    for (int i = 7; i >= 0; i--) if (img_hit(i, a, am)) begin n++; first = i; end
    eh = n > 0; ei = 3'(first); eo = n > 1;
    @(negedge clk);
    vme_addr = a; vme_am = am; as_valid = 1;
    @(negedge clk);
    as_valid = 0;
    check({req, " hit"}, 32'(hit), 32'(eh));
    check({req, " idx"}, 32'(hit_idx), 32'(ei));
    check({req, " overlap"}, 32'(overlap_err), 32'(eo));
    vme_addr = ~a; vme_am = ~am;
    @(negedge clk);
    check("R2 hold", {29'(hit), hit_idx[1:0], overlap_err}, {29'(eh), ei[1:0], eo});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] aml [14] = '{6'h2D, 6'h29, 6'h3D, 6'h3E, 6'h39, 6'h3A, 6'h0D,
                             6'h0E, 6'h09, 6'h0A, 6'h2F, 6'h10, 6'h1F, 6'h15};
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin m_ctl[i] = 0; m_base[i] = 0; m_bound[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 hit", 32'(hit), 0);
    check("R1 idx", 32'(hit_idx), 0);
    check("R1 overlap", 32'(overlap_err), 0);
    // R1 R8 default user codes
    setimg(1, 8'h81, 32'h1000_0000, 32'h1001_0000);
    phase("R1 user0", 32'h1000_0040, 6'h10);
    phase("R1 user1", 32'h1000_0040, 6'h1F);
    phase("R8 other", 32'h1000_0040, 6'h11);
    wr(2'd3, 0, 32'h0000_1A12);
    phase("R8 newcode", 32'h1000_0040, 6'h1A);
    phase("R8 oldcode", 32'h1000_0040, 6'h10);
    // R3 window edges, coarse image 1
    setimg(1, 8'h7D, 32'h2003_1234, 32'h2005_0000);
    phase("R3 base", 32'h2003_0000, 6'h0D);
    phase("R3 below", 32'h2002_FFFF, 6'h0D);
    phase("R3 last", 32'h2004_FFFF, 6'h0D);
    phase("R3 bound", 32'h2005_0000, 6'h0D);
    // R3 fine image 0
    setimg(0, 8'h7D, 32'h2003_1000, 32'h2003_3000);
    phase("R3 fine", 32'h2003_1000, 6'h0E);
    phase("R3 fine below", 32'h2003_0FFF, 6'h09);
    phase("R9 fine over", 32'h2003_3000, 6'h0A);
    // R4 empty window
    setimg(0, 8'h7D, 32'h3000_0000, 32'h3000_0000);
    phase("R4 empty", 32'h3000_0000, 6'h0D);
    // R5 disabled
    setimg(2, 8'h7C, 32'h4000_0000, 32'h5000_0000);
    phase("R5 disabled", 32'h4800_0000, 6'h0D);
    // R6 R7 spaces
    setimg(2, 8'h4B, 32'h4000_0000, 32'h5000_0000);
    phase("R6 a24 ok", 32'h4800_0000, 6'h3D);
    phase("R6 a24 prog", 32'h4800_0000, 6'h3E);
    phase("R6 a24 np", 32'h4800_0000, 6'h39);
    setimg(2, 8'h71, 32'h4000_0000, 32'h5000_0000);
    phase("R7 a16", 32'h4800_0000, 6'h29);
    phase("R7 a16 sup", 32'h4800_0000, 6'h2D);
    setimg(2, 8'h07, 32'h4000_0000, 32'h5000_0000);
    phase("R7 csr", 32'h4800_0000, 6'h2F);
    // R9 R10 overlap priority
    setimg(5, 8'h7D, 32'h4000_0000, 32'h4100_0000);
    setimg(6, 8'h7D, 32'h4000_0000, 32'h4100_0000);
    phase("R10 overlap", 32'h4080_0000, 6'h0D);
    phase("R9 miss", 32'h6000_0000, 6'h0D);
    // R11 random programming
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < 8; i++) begin
        int sh = (i == 0 || i == 4) ? 12 : 16;
        logic [31:0] b = 32'h8000_0000 + ($urandom_range(0, 15) << 16);
        logic [31:0] t = b + ($urandom_range(0, 4) << sh) + ($urandom_range(0, 3) << 16);
        logic [7:0] c = 8'($urandom);
        if ($urandom_range(0, 3) != 0) c[0] = 1;
        setimg(i, c, b, t);
      end
      for (int p = 0; p < 25; p++)
        phase("R11 random", 32'h8000_0000 + $urandom_range(0, 20 << 16), aml[$urandom_range(0, 13)]);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule